// File: doc/BRIEF.md
# DRAM Write-Command Spacing Tracker

This block sits in the command path of a DRAM controller. It reports whether a WRITE may go to a chosen rank and bank on the current DRAM clock. It watches each issued command, which is an ACT, a READ, a WRITE or some other command, together with its rank and bank. From these it keeps three kinds of saturating countdown:

- one countdown per rank-bank, started by ACT;
- one countdown per rank, started by WRITE;
- two global countdowns, one started by any WRITE (different-rank spacing) and one started by any READ.

A scheduler puts a candidate target on `tgt_rank`/`tgt_bank` and reads `wr_ok` in the same cycle.

All four minimum spacings come from one 16-bit configuration word, which software can rewrite at run time. A small state machine records whether any WRITE has been seen since reset, and to which rank. It has two states:

- `LW_NONE`: no WRITE seen since reset. This is the reset state.
- `LW_HELD`: a WRITE has been seen, and the rank of the most recent one is stored.

Transition `T_FIRST_WR` goes from `LW_NONE` to `LW_HELD` on the first issued WRITE. Transition `T_NEXT_WR` keeps the machine in `LW_HELD` and updates the stored rank on each later WRITE. Apart from reset there are no other transitions.

Top module: `wr_gap_tracker`

## Requirements
- R1: After reset the configuration word is 0000h and `wr_ok` is 1 for every target until a command is issued.
- R2: Bits 15:12 of the configuration word set the minimum spacing from an ACT to a WRITE on the same rank and bank. An ACT to one bank does not restrict WRITEs to any other bank.
- R3: Bits 11:8 set the minimum spacing between two WRITEs to the same rank. This applies whichever banks the two WRITEs use.
- R4: Bits 7:4 set the minimum spacing between a WRITE and a later WRITE to a different rank. This spacing only applies when the most recent WRITE went to a rank other than the target's. Before any WRITE it has no effect.
- R5: Bits 3:0 set the minimum spacing between any READ and a later WRITE to any rank and bank.
- R6: A spacing value N issued with a command in cycle t allows a WRITE in cycle t+N and in every later cycle. Values 0 and 1 impose no delay, so `wr_ok` is 1 in cycle t+1.
- R7: A configuration write in cycle t applies only to commands issued in cycle t+1 or later. A countdown that is already running keeps its loaded value.
- R8: `cmd_type` is encoded as 00 = ACT, 01 = READ, 10 = WRITE, 11 = other. A command with type 11, or any command with `cmd_valid` low, changes no countdown.
- R9: `wr_ok` is the AND of the conditions in R2, R3, R4 and R5 for the target. It is evaluated combinationally from the current target inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 16 | New configuration word (15:12 ACT-WR, 11:8 same-rank WR-WR, 7:4 other-rank WR-WR, 3:0 RD-WR) |
| cmd_valid | input | 1 | A command issues this cycle |
| cmd_type | input | 2 | Command type: 00 ACT, 01 READ, 10 WRITE, 11 other |
| cmd_rank | input | $clog2(RANKS) | Rank of the issued command |
| cmd_bank | input | $clog2(BANKS) | Bank of the issued command |
| tgt_rank | input | $clog2(RANKS) | Rank of the candidate WRITE |
| tgt_bank | input | $clog2(BANKS) | Bank of the candidate WRITE |
| wr_ok | output | 1 | The candidate WRITE may issue this cycle |

## Verification
A command presented in cycle t is captured at the clock edge that closes cycle t. Its restriction is therefore first visible in cycle t+1, and it lifts exactly in cycle t+N. Target changes show on `wr_ok` in the same cycle, with no register in between. The bench drives all inputs on the falling edge and compares `wr_ok` one nanosecond later against a behavioural model. That model stores the issue cycle and the spacing of each constraining command. The model is then advanced for the command of that cycle, so each comparison lands in the cycle in which the result is due, and every cycle is compared.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

    localparam int GAP_W = 4;
    localparam int CFG_W = 4 * GAP_W;

    typedef enum logic [1:0] {
        CMD_ACT   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_OTHER = 2'b11
    } cmd_e;

    // Field order follows the bit positions of the configuration word.
    typedef struct packed {
        logic [GAP_W-1:0] act_wr;
        logic [GAP_W-1:0] wr_same;
        logic [GAP_W-1:0] wr_diff;
        logic [GAP_W-1:0] rd_wr;
    } gap_cfg_t;

    typedef enum logic {
        LW_NONE = 1'b0,
        LW_HELD = 1'b1
    } lw_state_e;

endpackage

// File: rtl/wgt_cfg_reg.sv
module wgt_cfg_reg
    import wgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output gap_cfg_t         cfg
);

    gap_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= gap_cfg_t'(wdata);
        end
    end

    assign cfg = cfg_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/wgt_gap_cnt.sv
module wgt_gap_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] gap,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (gap == '0) ? '0 : gap - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired); // R6

    AST_CNT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (load && gap >= W'(2)) |=> !expired); // R6

endmodule

// File: rtl/wr_gap_tracker.sv
module wr_gap_tracker
    import wgt_pkg::*;
#(
    parameter  int RANKS  = 2,
    parameter  int BANKS  = 8,
    localparam int RANK_W = $clog2(RANKS),
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_type,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [RANK_W-1:0] tgt_rank,
    input  logic [BANK_W-1:0] tgt_bank,
    output logic              wr_ok
);

    localparam int RB_N = RANKS * BANKS;

    gap_cfg_t cfg;

    wgt_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    // Issue decode
    logic act_issue, rd_issue, wr_issue;
    assign act_issue = cmd_valid && (cmd_e'(cmd_type) == CMD_ACT);
    assign rd_issue  = cmd_valid && (cmd_e'(cmd_type) == CMD_READ);
    assign wr_issue  = cmd_valid && (cmd_e'(cmd_type) == CMD_WRITE);

    // Per rank-bank ACT-to-WRITE countdowns
    logic [RB_N-1:0]  act_exp;
    logic [RANKS-1:0] wsr_exp;

    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            wgt_gap_cnt #(.W(GAP_W)) u_act (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (act_issue && cmd_rank == RANK_W'(r) && cmd_bank == BANK_W'(b)),
                .gap     (cfg.act_wr),
                .expired (act_exp[r*BANKS+b])
            );
        end
        wgt_gap_cnt #(.W(GAP_W)) u_wsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (wr_issue && cmd_rank == RANK_W'(r)),
            .gap     (cfg.wr_same),
            .expired (wsr_exp[r])
        );
    end

    logic wdr_exp, rdw_exp;

    wgt_gap_cnt #(.W(GAP_W)) u_wdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_issue),
        .gap     (cfg.wr_diff),
        .expired (wdr_exp)
    );

    wgt_gap_cnt #(.W(GAP_W)) u_rdw (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rd_issue),
        .gap     (cfg.rd_wr),
        .expired (rdw_exp)
    );

    // Last-write tracking state machine
    lw_state_e         lw_q, lw_d;
    logic [RANK_W-1:0] last_rank_q, last_rank_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_q        <= LW_NONE;
            last_rank_q <= '0;
        end else begin
            lw_q        <= lw_d;
            last_rank_q <= last_rank_d;
        end
    end

    always_comb begin
        lw_d        = lw_q;
        last_rank_d = last_rank_q;
        unique case (lw_q)
            LW_NONE: begin
                if (wr_issue) begin          // T_FIRST_WR
                    lw_d        = LW_HELD;
                    last_rank_d = cmd_rank;
                end
            end
            LW_HELD: begin
                if (wr_issue) begin          // T_NEXT_WR
                    last_rank_d = cmd_rank;
                end
            end
            default: lw_d = LW_NONE;
        endcase
    end

    // Output: combine the four conditions for the target
    logic act_ok, wsr_ok, wdr_ok;

    always_comb begin
        act_ok = 1'b0;
        wsr_ok = 1'b0;
        for (int i = 0; i < RB_N; i++) begin
            if (i == int'(tgt_rank) * BANKS + int'(tgt_bank)) act_ok = act_exp[i];
        end
        for (int r = 0; r < RANKS; r++) begin
            if (r == int'(tgt_rank)) wsr_ok = wsr_exp[r];
        end
        wdr_ok = (lw_q == LW_NONE) || (last_rank_q == tgt_rank) || wdr_exp;
        wr_ok  = act_ok && wsr_ok && wdr_ok && rdw_exp;
    end

    AST_ACT_BLOCKS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (act_issue && cfg.act_wr >= 4'd2)
        |=> !(wr_ok && tgt_rank == $past(cmd_rank) && tgt_bank == $past(cmd_bank))); // R2

    AST_WR_BLOCKS_RANK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_issue && cfg.wr_same >= 4'd2)
        |=> !(wr_ok && tgt_rank == $past(cmd_rank))); // R3

    AST_WR_BLOCKS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_issue && cfg.wr_diff >= 4'd2)
        |=> !(wr_ok && tgt_rank != $past(cmd_rank))); // R4

    AST_RD_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && cfg.rd_wr >= 4'd2) |=> !wr_ok); // R5

    AST_OTHER_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_issue) |=> (lw_q == $past(lw_q) && last_rank_q == $past(last_rank_q))); // R8

endmodule

// File: tb/sim_wr_gap_tracker.sv
`timescale 1ns/1ps
module sim_wr_gap_tracker;

    localparam int RANKS = 2;
    localparam int BANKS = 8;
    localparam int RANK_W = $clog2(RANKS);
    localparam int BANK_W = $clog2(BANKS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [15:0]       cfg_wdata = '0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_type = 2'b11;
    logic [RANK_W-1:0] cmd_rank = '0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic [RANK_W-1:0] tgt_rank = '0;
    logic [BANK_W-1:0] tgt_bank = '0;
    logic              wr_ok;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    wr_gap_tracker #(.RANKS(RANKS), .BANKS(BANKS)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_rank(cmd_rank),
        .cmd_bank(cmd_bank), .tgt_rank(tgt_rank), .tgt_bank(tgt_bank),
        .wr_ok(wr_ok)
    );

    // Behavioural reference: issue cycle and spacing of each constraint
    int m_cfg;
    int act_t [RANKS][BANKS];
    int act_n [RANKS][BANKS];
    int wsr_t [RANKS];
    int wsr_n [RANKS];
    int wdr_t, wdr_n, rd_t, rd_n, last_r;
    bit have_w;

    task automatic model_reset();
        m_cfg = 0;
        for (int r = 0; r < RANKS; r++) begin
            wsr_t[r] = -1000; wsr_n[r] = 0;
            for (int b = 0; b < BANKS; b++) begin
                act_t[r][b] = -1000; act_n[r][b] = 0;
            end
        end
        wdr_t = -1000; wdr_n = 0; rd_t = -1000; rd_n = 0;
        last_r = 0; have_w = 0;
    endtask

    function automatic bit model_ok(int tr, int tb);
        bit ok = 1;
        if (cyc - act_t[tr][tb] < act_n[tr][tb]) ok = 0;
        if (cyc - wsr_t[tr] < wsr_n[tr]) ok = 0;
        if (have_w && last_r != tr && cyc - wdr_t < wdr_n) ok = 0;
        if (cyc - rd_t < rd_n) ok = 0;
        return ok;
    endfunction

    task automatic step(bit v, int ty, int cr, int cb, int tr, int tb,
                        bit we, int wd, string tag);
        bit exp_ok;
        @(negedge clk);
        cmd_valid = v; cmd_type = 2'(ty); cmd_rank = RANK_W'(cr); cmd_bank = BANK_W'(cb);
        tgt_rank = RANK_W'(tr); tgt_bank = BANK_W'(tb);
        cfg_we = we; cfg_wdata = 16'(wd);
        #1;
        exp_ok = model_ok(tr, tb);
        n_tests++;
        if (wr_ok !== exp_ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d target r%0d b%0d: wr_ok=%0b expected %0b",
                     tag, cyc, tr, tb, wr_ok, exp_ok);
        end
        if (v) begin
            case (ty)
                0: begin act_t[cr][cb] = cyc; act_n[cr][cb] = (m_cfg >> 12) & 15; end
                1: begin rd_t = cyc; rd_n = m_cfg & 15; end
                2: begin
                    wsr_t[cr] = cyc; wsr_n[cr] = (m_cfg >> 8) & 15;
                    wdr_t = cyc; wdr_n = (m_cfg >> 4) & 15;
                    last_r = cr; have_w = 1;
                end
                default: ;
            endcase
        end
        if (we) m_cfg = wd & 16'hFFFF;
        cyc++;
    endtask

    task automatic idle_probe(int tr, int tb, int n, string tag);
        for (int i = 0; i < n; i++) step(0, 3, 0, 0, tr, tb, 0, 0, tag);
    endtask

    task automatic set_cfg(int wd, string tag);
        step(0, 3, 0, 0, 0, 0, 1, wd, tag);
        idle_probe(0, 0, 16, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every target free
        for (int r = 0; r < RANKS; r++)
            for (int b = 0; b < BANKS; b++) step(0, 3, 0, 0, r, b, 0, 0, "R1");

        // R2: ACT to r0 b3 with spacing 5; same bank blocked, neighbour free
        set_cfg(16'h5000, "R2");
        step(1, 0, 0, 3, 0, 3, 0, 0, "R2");
        for (int i = 0; i < 6; i++) begin
            step(0, 3, 0, 0, 0, 3, 0, 0, "R2");
            step(0, 3, 0, 0, 0, 4, 0, 0, "R2");
        end

        // R3: same-rank spacing 4 across banks
        set_cfg(16'h0400, "R3");
        step(1, 2, 1, 0, 1, 5, 0, 0, "R3");
        idle_probe(1, 5, 5, "R3");
        step(1, 2, 1, 2, 0, 1, 0, 0, "R3");
        step(0, 3, 0, 0, 0, 1, 0, 0, "R3");

        // R4: other-rank spacing 3; no effect on the same rank
        set_cfg(16'h0030, "R4");
        step(1, 2, 0, 6, 1, 0, 0, 0, "R4");
        for (int i = 0; i < 4; i++) begin
            step(0, 3, 0, 0, 1, 0, 0, 0, "R4");
            step(0, 3, 0, 0, 0, 0, 0, 0, "R4");
        end

        // R5: read-to-write spacing 3, any target
        set_cfg(16'h0003, "R5");
        step(1, 1, 1, 2, 0, 0, 0, 0, "R5");
        idle_probe(0, 7, 2, "R5");
        idle_probe(1, 2, 2, "R5");

        // R6: spacings of 1 and 0 impose no delay
        set_cfg(16'h1111, "R6");
        step(1, 0, 1, 1, 1, 1, 0, 0, "R6");
        step(0, 3, 0, 0, 1, 1, 0, 0, "R6");
        step(1, 2, 1, 1, 1, 1, 0, 0, "R6");
        step(0, 3, 0, 0, 0, 1, 0, 0, "R6");
        step(1, 1, 0, 0, 1, 1, 0, 0, "R6");
        step(0, 3, 0, 0, 1, 1, 0, 0, "R6");
        set_cfg(16'h0000, "R6");
        step(1, 2, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 3, 0, 0, 1, 0, 0, 0, "R6");

        // R7: rewrite during a running countdown; new value only for new commands
        set_cfg(16'h6000, "R7");
        step(1, 0, 0, 0, 0, 0, 1, 16'h0000, "R7");
        idle_probe(0, 0, 7, "R7");
        step(1, 0, 0, 1, 0, 1, 1, 16'hF000, "R7");
        step(0, 3, 0, 0, 0, 1, 0, 0, "R7");
        idle_probe(0, 0, 16, "R7");

        // R8: type 11 and strobe low leave every countdown alone
        set_cfg(16'hFFFF, "R8");
        step(1, 3, 1, 4, 1, 4, 0, 0, "R8");
        step(0, 2, 1, 4, 1, 4, 0, 0, "R8");
        step(0, 0, 1, 4, 1, 4, 0, 0, "R8");
        step(0, 1, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 3, 0, 0, 1, 4, 0, 0, "R8");

        // R9: mixed random traffic, every cycle compared
        for (int i = 0; i < 4000; i++) begin
            int rv = $urandom;
            bit we = ((rv & 63) == 0);
            step((rv >> 6) % 10 < 6, (rv >> 10) & 3, (rv >> 12) & 1, (rv >> 13) & 7,
                 (rv >> 16) & 1, (rv >> 17) & 7, we, $urandom & 16'h7777, "R9");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule